// File: doc/BRIEF.md
# PMP access permission checker

This block decides whether one memory access may proceed under a set of physical memory protection entries. Each request carries an address, a byte count, the requested read/write/execute kinds and whether the requester runs in machine mode. Per-entry inclusive lower and upper byte bounds and an 8-bit configuration byte per entry arrive as flat input vectors, so the logic that turns programmed addresses into bounds lives elsewhere. Two security bits select the lockdown and whitelist policies.

The block tests the first and last byte of the access against every active entry and lets the lowest-numbered active entry that touches the access decide. An access that only partly falls inside that entry is refused. A matching entry's permissions come from either the classic rules or, under lockdown, from two 16-way truth tables indexed by the entry's lock and permission bits. When nothing matches, a default policy applies. The allowed set, the deciding entry, a default flag and a grant bit are registered one cycle after the request.

Top module: `pmp_access_checker`

## Requirements
- R1: The configuration byte of an entry uses bit 0 as R, bit 1 as W, bit 2 as X, bits 4:3 as the match mode and bit 7 as the lock; a match mode of 0 means the entry is off and is ignored entirely. Permission vectors on ports use bit 0 = R, bit 1 = W, bit 2 = X.
- R2: An entry contains a byte when lower bound <= byte <= upper bound. The first byte is the request address and the last byte is address + size - 1, where a size of 0 counts as WORD_BYTES bytes.
- R3: The lowest-index active entry that contains both bytes decides the access: resp_hit is 1 and resp_idx is its index; higher entries are not consulted.
- R4: If the lowest-index active entry containing either byte contains only one of them, the access is refused: resp_allow = 0, resp_hit = 0, resp_default = 0, resp_idx = 0 and resp_grant = 0.
- R5: Without lockdown, a matched entry gives machine mode R, W and X when the entry's lock bit is clear; otherwise the allowed set equals the entry's R/W/X bits.
- R6: With lockdown, a 4-bit index {lock, R, W, X} (lock in bit 3) selects machine-mode permissions: 2, 3, 14 give RW; 9, 10 give X; 11, 13 give RX; 12, 15 give R; all other values give nothing.
- R7: With lockdown, the same index selects non-machine permissions: 1, 10, 11 give X; 2, 4, 15 give R; 3, 6 give RW; 5 gives RX; 7 gives RWX; all other values give nothing.
- R8: When no entry decides and no straddle occurs, resp_default is 1; with the whitelist bit set the allowed set is empty for every mode.
- R9: With no match, lockdown set and whitelist clear, a machine-mode request without X gets RW; any other request gets nothing.
- R10: With no match and both security bits clear, machine mode gets RWX and other modes get nothing.
- R11: resp_grant is 1 exactly when the access is not a straddle and every requested R/W/X bit is inside resp_allow.
- R12: resp_valid equals req_valid delayed by one clock; the result registers change only in the cycle after a valid request and otherwise hold; reset clears them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Byte count, 0 means one machine word |
| req_type | input | 3 | Requested kinds, bit 0 R, bit 1 W, bit 2 X |
| req_mmode | input | 1 | Requester runs in machine mode |
| sec_lockdown | input | 1 | Machine-mode lockdown policy enabled |
| sec_whitelist | input | 1 | Deny-by-default for all modes |
| entry_lo | input | NUM_ENTRIES*ADDR_W | Inclusive lower bounds, entry i in slice i |
| entry_hi | input | NUM_ENTRIES*ADDR_W | Inclusive upper bounds, entry i in slice i |
| entry_cfg | input | NUM_ENTRIES*8 | Configuration bytes, entry i in slice i |
| resp_valid | output | 1 | Result present |
| resp_allow | output | 3 | Allowed kinds, bit 0 R, bit 1 W, bit 2 X |
| resp_hit | output | 1 | An entry decided the access |
| resp_idx | output | IDX_W | Index of the deciding entry, 0 otherwise |
| resp_default | output | 1 | Default policy decided the access |
| resp_grant | output | 1 | Access allowed |

## Verification
The bench builds the checker with four entries, a 16-bit address, a 4-bit size and a 4-byte word. Four entries are enough to place an off entry that covers the whole space between active ones, so ignoring off entries and lowest-index priority are both observable, and the 4-byte word makes a zero-size access reach across an entry edge that a one-byte access would not. The small address width keeps every bound and straddle case written as short constants, and all sixteen lockdown indices are walked in both modes on a single entry.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef logic [2:0] perm_t;

    localparam perm_t PERM_NONE = 3'b000;
    localparam perm_t PERM_R    = 3'b001;
    localparam perm_t PERM_W    = 3'b010;
    localparam perm_t PERM_X    = 3'b100;
    localparam perm_t PERM_RW   = PERM_R | PERM_W;
    localparam perm_t PERM_RX   = PERM_R | PERM_X;
    localparam perm_t PERM_RWX  = PERM_R | PERM_W | PERM_X;

    localparam int CFG_W       = 8;
    localparam int CFG_R_BIT   = 0;
    localparam int CFG_W_BIT   = 1;
    localparam int CFG_X_BIT   = 2;
    localparam int CFG_MODE_LO = 3;
    localparam int CFG_LOCK_BIT = 7;

    typedef enum logic [1:0] {
        DEC_DEFAULT  = 2'd0,
        DEC_ENTRY    = 2'd1,
        DEC_STRADDLE = 2'd2
    } decision_e;

    typedef struct packed {
        perm_t allow;
        logic  hit;
        logic  dflt;
        logic  grant;
    } verdict_t;

    function automatic logic cfg_active(input logic [CFG_W-1:0] cfg);
        return cfg[CFG_MODE_LO +: 2] != 2'b00;
    endfunction

    function automatic logic [3:0] lockdown_index(input logic [CFG_W-1:0] cfg);
        return {cfg[CFG_LOCK_BIT], cfg[CFG_R_BIT], cfg[CFG_W_BIT], cfg[CFG_X_BIT]};
    endfunction

    function automatic perm_t ld_mmode_perm(input logic [3:0] k);
        perm_t p;
        case (k)
            4'd2, 4'd3, 4'd14: p = PERM_RW;
            4'd9, 4'd10:       p = PERM_X;
            4'd11, 4'd13:      p = PERM_RX;
            4'd12, 4'd15:      p = PERM_R;
            default:           p = PERM_NONE;
        endcase
        return p;
    endfunction

    function automatic perm_t ld_lower_perm(input logic [3:0] k);
        perm_t p;
        case (k)
            4'd1, 4'd10, 4'd11: p = PERM_X;
            4'd2, 4'd4, 4'd15:  p = PERM_R;
            4'd3, 4'd6:         p = PERM_RW;
            4'd5:               p = PERM_RX;
            4'd7:               p = PERM_RWX;
            default:            p = PERM_NONE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pmp_range_match.sv
module pmp_range_match #(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 32
) (
    input  logic [NUM_ENTRIES*ADDR_W-1:0] lo_flat,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] hi_flat,
    input  logic [ADDR_W-1:0]             first_byte,
    input  logic [ADDR_W-1:0]             last_byte,
    output logic [NUM_ENTRIES-1:0]        in_first,
    output logic [NUM_ENTRIES-1:0]        in_last
);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        logic [ADDR_W-1:0] lo_b;
        logic [ADDR_W-1:0] hi_b;
        assign lo_b = lo_flat[g*ADDR_W +: ADDR_W];
        assign hi_b = hi_flat[g*ADDR_W +: ADDR_W];
        assign in_first[g] = (first_byte >= lo_b) && (first_byte <= hi_b);
        assign in_last[g]  = (last_byte  >= lo_b) && (last_byte  <= hi_b);
    end

endmodule

// File: rtl/pmp_priority_pick.sv
module pmp_priority_pick
    import pmp_chk_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic [NUM_ENTRIES-1:0] active,
    input  logic [NUM_ENTRIES-1:0] in_first,
    input  logic [NUM_ENTRIES-1:0] in_last,
    output decision_e              decision,
    output logic [IDX_W-1:0]       win_idx
);

    always_comb begin
        logic settled;
        settled  = 1'b0;
        decision = DEC_DEFAULT;
        win_idx  = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (!settled && active[i]) begin
                if (in_first[i] && in_last[i]) begin
                    decision = DEC_ENTRY;
                    win_idx  = IDX_W'(i);
                    settled  = 1'b1;
                end else if (in_first[i] ^ in_last[i]) begin
                    decision = DEC_STRADDLE;
                    settled  = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
    import pmp_chk_pkg::*;
(
    input  decision_e         decision,
    input  logic [CFG_W-1:0]  win_cfg,
    input  logic              mmode,
    input  logic              lockdown,
    input  logic              whitelist,
    input  perm_t             req_kind,
    output verdict_t          verdict
);

    perm_t entry_perm;
    perm_t dflt_perm;

    always_comb begin
        if (lockdown) begin
            entry_perm = mmode ? ld_mmode_perm(lockdown_index(win_cfg))
                               : ld_lower_perm(lockdown_index(win_cfg));
        end else if (mmode && !win_cfg[CFG_LOCK_BIT]) begin
            entry_perm = PERM_RWX;
        end else begin
            entry_perm = win_cfg[2:0];
        end
    end

    always_comb begin
        if (whitelist) begin
            dflt_perm = PERM_NONE;
        end else if (lockdown) begin
            dflt_perm = (mmode && !req_kind[2]) ? PERM_RW : PERM_NONE;
        end else begin
            dflt_perm = mmode ? PERM_RWX : PERM_NONE;
        end
    end

    always_comb begin
        verdict = '0;
        unique case (decision)
            DEC_ENTRY: begin
                verdict.allow = entry_perm;
                verdict.hit   = 1'b1;
            end
            DEC_DEFAULT: begin
                verdict.allow = dflt_perm;
                verdict.dflt  = 1'b1;
            end
            default: verdict.allow = PERM_NONE;
        endcase
        verdict.grant = (decision != DEC_STRADDLE) &&
                        ((req_kind & ~verdict.allow) == PERM_NONE);
    end

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
    import pmp_chk_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 8,
    parameter int WORD_BYTES  = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [SIZE_W-1:0]             req_size,
    input  logic [2:0]                    req_type,
    input  logic                          req_mmode,
    input  logic                          sec_lockdown,
    input  logic                          sec_whitelist,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] entry_lo,
    input  logic [NUM_ENTRIES*ADDR_W-1:0] entry_hi,
    input  logic [NUM_ENTRIES*CFG_W-1:0]  entry_cfg,
    output logic                          resp_valid,
    output logic [2:0]                    resp_allow,
    output logic                          resp_hit,
    output logic [IDX_W-1:0]              resp_idx,
    output logic                          resp_default,
    output logic                          resp_grant
);

    localparam logic [ADDR_W-1:0] WORD_SPAN = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0]      span;
    logic [ADDR_W-1:0]      last_byte;
    logic [NUM_ENTRIES-1:0] active;
    logic [NUM_ENTRIES-1:0] in_first;
    logic [NUM_ENTRIES-1:0] in_last;
    decision_e              decision;
    logic [IDX_W-1:0]       win_idx;
    logic [CFG_W-1:0]       win_cfg;
    verdict_t               verdict;
    verdict_t               verdict_q;
    logic [IDX_W-1:0]       idx_q;
    logic                   valid_q;

    assign span      = (req_size == '0) ? WORD_SPAN : ADDR_W'(req_size);
    assign last_byte = req_addr + span - ADDR_W'(1);

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_act
        assign active[g] = cfg_active(entry_cfg[g*CFG_W +: CFG_W]);
    end

    pmp_range_match #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .ADDR_W      (ADDR_W)
    ) u_match (
        .lo_flat    (entry_lo),
        .hi_flat    (entry_hi),
        .first_byte (req_addr),
        .last_byte  (last_byte),
        .in_first   (in_first),
        .in_last    (in_last)
    );

    pmp_priority_pick #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_pick (
        .active   (active),
        .in_first (in_first),
        .in_last  (in_last),
        .decision (decision),
        .win_idx  (win_idx)
    );

    assign win_cfg = entry_cfg[win_idx*CFG_W +: CFG_W];

    pmp_perm_eval u_eval (
        .decision  (decision),
        .win_cfg   (win_cfg),
        .mmode     (req_mmode),
        .lockdown  (sec_lockdown),
        .whitelist (sec_whitelist),
        .req_kind  (req_type),
        .verdict   (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            verdict_q <= '0;
            idx_q     <= '0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                verdict_q <= verdict;
                idx_q     <= (decision == DEC_ENTRY) ? win_idx : '0;
            end
        end
    end

    assign resp_valid   = valid_q;
    assign resp_allow   = verdict_q.allow;
    assign resp_hit     = verdict_q.hit;
    assign resp_idx     = idx_q;
    assign resp_default = verdict_q.dflt;
    assign resp_grant   = verdict_q.grant;

endmodule

// File: rtl/pmp_access_checker_chk.sv
module pmp_access_checker_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_type,
    input logic       sec_whitelist,
    input logic       resp_valid,
    input logic [2:0] resp_allow,
    input logic       resp_hit,
    input logic       resp_default,
    input logic       resp_grant
);

    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    // R12
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(resp_allow) && $stable(resp_grant) &&
                        $stable(resp_hit) && $stable(resp_default)));

    // R11
    grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_grant) |-> (($past(req_type) & ~resp_allow) == 3'b000));

    // R3
    hit_dflt_excl_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !(resp_hit && resp_default));

    // R4
    straddle_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_hit && !resp_default) |-> (resp_allow == 3'b000 && !resp_grant));

    // R8
    whitelist_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_default && $past(sec_whitelist)) |-> (resp_allow == 3'b000));

endmodule

bind pmp_access_checker pmp_access_checker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_type      (req_type),
    .sec_whitelist (sec_whitelist),
    .resp_valid    (resp_valid),
    .resp_allow    (resp_allow),
    .resp_hit      (resp_hit),
    .resp_default  (resp_default),
    .resp_grant    (resp_grant)
);

// File: tb/pmp_access_checker_tb.sv
module pmp_access_checker_tb;

    localparam int NE = 4;
    localparam int AW = 16;
    localparam int SW = 4;
    localparam int IW = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [SW-1:0]   req_size = '0;
    logic [2:0]      req_type = '0;
    logic            req_mmode = 1'b0;
    logic            sec_lockdown = 1'b0;
    logic            sec_whitelist = 1'b0;
    logic [NE*AW-1:0] entry_lo;
    logic [NE*AW-1:0] entry_hi;
    logic [NE*8-1:0]  entry_cfg;
    logic            resp_valid;
    logic [2:0]      resp_allow;
    logic            resp_hit;
    logic [IW-1:0]   resp_idx;
    logic            resp_default;
    logic            resp_grant;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pmp_access_checker #(
        .NUM_ENTRIES (NE),
        .ADDR_W      (AW),
        .SIZE_W      (SW),
        .WORD_BYTES  (4)
    ) u_dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_size      (req_size),
        .req_type      (req_type),
        .req_mmode     (req_mmode),
        .sec_lockdown  (sec_lockdown),
        .sec_whitelist (sec_whitelist),
        .entry_lo      (entry_lo),
        .entry_hi      (entry_hi),
        .entry_cfg     (entry_cfg),
        .resp_valid    (resp_valid),
        .resp_allow    (resp_allow),
        .resp_hit      (resp_hit),
        .resp_idx      (resp_idx),
        .resp_default  (resp_default),
        .resp_grant    (resp_grant)
    );

    typedef struct packed {
        logic [15:0] addr;
        logic [3:0]  size;
        logic [2:0]  kind;
        logic        mm;
        logic        ld;
        logic        wl;
        logic [2:0]  allow;
        logic        hit;
        logic [1:0]  idx;
        logic        dflt;
        logic        grant;
    } vec_t;

    // Entry 0: 0x0100..0x01FF R, unlocked. Entry 1: 0x0180..0x02FF RW, locked.
    // Entry 2: off, covers all. Entry 3: 0x1000..0x1FFF X only.
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{16'h0100, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 3'b001, 1'b1, 2'd0, 1'b0, 1'b1}, // R3 R5
        '{16'h0100, 4'd4, 3'b010, 1'b0, 1'b0, 1'b0, 3'b001, 1'b1, 2'd0, 1'b0, 1'b0}, // R11
        '{16'h0100, 4'd4, 3'b010, 1'b1, 1'b0, 1'b0, 3'b111, 1'b1, 2'd0, 1'b0, 1'b1}, // R5 unlocked M
        '{16'h01FE, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0, 1'b0, 1'b0}, // R4
        '{16'h0200, 4'd4, 3'b010, 1'b1, 1'b0, 1'b0, 3'b011, 1'b1, 2'd1, 1'b0, 1'b1}, // R5 locked M
        '{16'h0200, 4'd4, 3'b100, 1'b1, 1'b0, 1'b0, 3'b011, 1'b1, 2'd1, 1'b0, 1'b0}, // R5 R11
        '{16'h0180, 4'd4, 3'b010, 1'b0, 1'b0, 1'b0, 3'b001, 1'b1, 2'd0, 1'b0, 1'b0}, // R3 priority
        '{16'h02FE, 4'd4, 3'b001, 1'b1, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0, 1'b0, 1'b0}, // R4 on entry 1
        '{16'h3000, 4'd4, 3'b001, 1'b1, 1'b0, 1'b0, 3'b111, 1'b0, 2'd0, 1'b1, 1'b1}, // R1 R10
        '{16'h3000, 4'd4, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0, 1'b1, 1'b0}, // R10
        '{16'h01FC, 4'd0, 3'b001, 1'b0, 1'b0, 1'b0, 3'b001, 1'b1, 2'd0, 1'b0, 1'b1}, // R2 word fits
        '{16'h01FD, 4'd0, 3'b001, 1'b0, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0, 1'b0, 1'b0}, // R2 word straddles
        '{16'h01FF, 4'd1, 3'b001, 1'b0, 1'b0, 1'b0, 3'b001, 1'b1, 2'd0, 1'b0, 1'b1}, // R2 single byte
        '{16'h3000, 4'd4, 3'b001, 1'b1, 1'b0, 1'b1, 3'b000, 1'b0, 2'd0, 1'b1, 1'b0}, // R8
        '{16'h3000, 4'd4, 3'b011, 1'b1, 1'b1, 1'b0, 3'b011, 1'b0, 2'd0, 1'b1, 1'b1}, // R9
        '{16'h3000, 4'd4, 3'b100, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 2'd0, 1'b1, 1'b0}, // R9
        '{16'h3000, 4'd4, 3'b001, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 2'd0, 1'b1, 1'b0}, // R9
        '{16'h1000, 4'd8, 3'b100, 1'b0, 1'b0, 1'b0, 3'b100, 1'b1, 2'd3, 1'b0, 1'b1}  // R5 entry 3
    };

    // R6 machine-mode and R7 lower-mode lockdown tables, indexed {L,R,W,X}
    localparam logic [2:0] MM_TAB [16] = '{
        3'b000, 3'b000, 3'b011, 3'b011, 3'b000, 3'b000, 3'b000, 3'b000,
        3'b000, 3'b100, 3'b100, 3'b101, 3'b001, 3'b101, 3'b011, 3'b001};
    localparam logic [2:0] UM_TAB [16] = '{
        3'b000, 3'b100, 3'b001, 3'b011, 3'b001, 3'b101, 3'b011, 3'b111,
        3'b000, 3'b000, 3'b100, 3'b100, 3'b000, 3'b000, 3'b000, 3'b001};

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] a, input logic [3:0] s, input logic [2:0] k,
                         input logic mm, input logic ld, input logic wl);
        @(negedge clk);
        req_addr = a; req_size = s; req_type = k; req_mmode = mm;
        sec_lockdown = ld; sec_whitelist = wl; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [8:0] outs();
        return {resp_valid, resp_allow, resp_hit, resp_idx, resp_default, resp_grant};
    endfunction

    initial begin
        entry_lo  = {16'h1000, 16'h0000, 16'h0180, 16'h0100};
        entry_hi  = {16'h1FFF, 16'hFFFF, 16'h02FF, 16'h01FF};
        entry_cfg = {8'h0C, 8'h07, 8'h8B, 8'h09};
        repeat (3) @(negedge clk);
        check("R12 reset state", outs(), 9'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 idle after reset", outs(), 9'b0);

        for (int v = 0; v < NV; v++) begin
            issue(VECS[v].addr, VECS[v].size, VECS[v].kind, VECS[v].mm, VECS[v].ld, VECS[v].wl);
            check($sformatf("R1-table vector %0d", v), outs(),
                  {1'b1, VECS[v].allow, VECS[v].hit, VECS[v].idx, VECS[v].dflt, VECS[v].grant});
        end

        // R12: no request, changed inputs, outputs hold and valid drops
        @(negedge clk);
        req_addr = 16'h0100; req_type = 3'b001; req_mmode = 1'b1;
        repeat (2) @(negedge clk);
        check("R12 hold without request", outs(), {1'b0, 3'b100, 1'b1, 2'd3, 1'b0, 1'b1});

        // R6 and R7: walk every lockdown index on entry 3
        for (int k = 0; k < 16; k++) begin
            logic [3:0] kk;
            kk = 4'(k);
            entry_cfg[31:24] = {kk[3], 2'b00, 2'b01, kk[0], kk[1], kk[2]};
            issue(16'h1000, 4'd4, 3'b001, 1'b1, 1'b1, 1'b0);
            check($sformatf("R6 index %0d", k), outs(),
                  {1'b1, MM_TAB[k], 1'b1, 2'd3, 1'b0, MM_TAB[k][0]});
            issue(16'h1000, 4'd4, 3'b001, 1'b0, 1'b1, 1'b0);
            check($sformatf("R7 index %0d", k), outs(),
                  {1'b1, UM_TAB[k], 1'b1, 2'd3, 1'b0, UM_TAB[k][0]});
        end

        // R1: entry 3 turned off, access falls to default
        entry_cfg[31:24] = 8'h04;
        issue(16'h1000, 4'd4, 3'b100, 1'b0, 1'b0, 1'b0);
        check("R1 off entry ignored", outs(), {1'b1, 3'b000, 1'b0, 2'd0, 1'b1, 1'b0});

        // R12: reset clears a held result
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R12 reset clears", outs(), 9'b0);
        rst = 1'b0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule